// File: doc/BRIEF.md
# Sparse-Space Bus Address Translator

This block sits between a host port that issues sparse-space loads and stores and a narrow 32-bit downstream bus. In sparse space the downstream address is stored in the host address shifted up by five bit positions, and the low host bits do not carry address. Instead they carry a transfer-length code. The block decodes the length and the byte offset from those low bits and forms byte enables. It places write data in the correct byte lane and pulls the selected bytes out of the returned read data. It also picks the target space by comparing the upper host bits against two region tags, one for sparse memory and one for I/O.

For the memory region, the upper downstream address bits come from a small high-address-extension register that the host loads through its own write strobe. Requests are handled one at a time. The host side has a valid/ready handshake. The downstream request is registered and held until the bus takes it, and the bus then signals completion with an acknowledge. Illegal requests are answered with an error response, and nothing is sent downstream for them.

Top module: `sparse_xlate`

## Requirements
- R1: After reset, req_ready is 1, dn_valid is 0, rsp_valid is 0, and the extension register holds 0.
- R2: The host address is split into these fields:
  - req_addr[2:0] is ignored.
  - req_addr[6:5] is the byte offset.
  - dn_addr[26:2] equals req_addr[31:7].
  - dn_addr[1:0] is always 0.
- R3: The length code req_addr[4:3] decodes as 00 = byte, 01 = 16-bit word, 11 = 32-bit longword. The byte enables are:
  - byte: 1 shifted left by the offset.
  - word: 2'b11 shifted left by the offset.
  - longword: 4'hF.
- R4: The memory region is selected when req_addr[39:32] == 8'h02. In that region:
  - dn_addr[31:29] holds the extension register value captured when the request is accepted.
  - dn_addr[28:27] is 0.
  - dn_io is 0.
  - A write with ext_we applies to requests accepted on later clock edges.
- R5: The I/O region is selected when req_addr[39:32] == 8'h03. In that region, dn_addr[31:27] is 0 whatever the extension register holds, and dn_io is 1.
- R6: On writes, dn_wdata is the low-aligned byte or word of req_wdata moved up by 8×offset, and every lane not enabled is zero. On reads, dn_wdata is 0.
- R7: For a read, rsp_rdata depends on the length:
  - byte: dn_rdata byte lane [offset], zero-extended.
  - word: the 16 bits starting at that lane, zero-extended.
  - longword: all 32 bits.

  For a write, rsp_rdata is 0.
- R8: Each of the following is illegal:
  - length code 10;
  - a word at offset 3;
  - a longword at a non-zero offset;
  - a region tag other than 02 or 03.

  An illegal request produces rsp_valid with rsp_err in the cycle after acceptance, and dn_valid never rises for it.
- R9: At most one request is outstanding:
  - req_ready is 1 only when idle.
  - dn_valid rises in the cycle after acceptance and is held, with stable fields, until dn_ready.
  - rsp_valid is a one-cycle pulse in the cycle after dn_ack.
- R10: Two longword requests at host addresses H and H+0x80 produce downstream addresses that differ by exactly 4, which is how a 64-bit access is split into its low and high halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_we | input | 1 | Load strobe for the extension register |
| ext_wdata | input | EXT_W (3) | New extension register value |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_addr | input | HADDR_W (40) | Host sparse address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Low-aligned store data |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream bus takes the request |
| dn_addr | output | DADDR_W (32) | Downstream address, bits 1:0 zero |
| dn_be | output | 4 | Byte enables |
| dn_write | output | 1 | Downstream direction |
| dn_wdata | output | 32 | Lane-placed write data |
| dn_io | output | 1 | 1 = I/O space, 0 = memory space |
| dn_ack | input | 1 | Downstream completion |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ack |
| rsp_valid | output | 1 | Host response pulse |
| rsp_rdata | output | 32 | Extracted read data |
| rsp_err | output | 1 | Request was illegal |

## Verification
The bench targets these corner cases:
- **Byte at offset 3 and word at offset 2.** Here a lane shift that is off by one would drop or wrap bytes on both the write and the read path.
- **Extension register loaded just before a request.** A design that sampled the register late, or applied it to I/O addresses, would show wrong upper address bits.
- **Each illegal form.** A decoder that missed one would send a transaction downstream instead of raising an error.
- **Delayed ready and acknowledge.** These catch a request that changes while the bus stalls.

Requests with junk in the ignored low bits are also included, as is a split 64-bit pair. These catch address bits taken from the wrong position.

// File: rtl/sx_pkg.sv
package sx_pkg;

  localparam int unsigned SX_LANES = 4;
  localparam int unsigned SX_DW    = 8 * SX_LANES;

  typedef enum logic [1:0] {
    LEN_BYTE = 2'b00,
    LEN_WORD = 2'b01,
    LEN_RSVD = 2'b10,
    LEN_LONG = 2'b11
  } sx_len_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } sx_state_e;

  // Data mask for the transfer size, low-aligned.
  function automatic logic [SX_DW-1:0] sx_mask(sx_len_e len);
    case (len)
      LEN_BYTE: return 32'h0000_00FF;
      LEN_WORD: return 32'h0000_FFFF;
      LEN_LONG: return 32'hFFFF_FFFF;
      default:  return '0;
    endcase
  endfunction

  function automatic logic [SX_LANES-1:0] sx_be(sx_len_e len, logic [1:0] off);
    case (len)
      LEN_BYTE: return 4'b0001 << off;
      LEN_WORD: return 4'b0011 << off;
      LEN_LONG: return 4'b1111;
      default:  return '0;
    endcase
  endfunction

  function automatic logic sx_len_ok(sx_len_e len, logic [1:0] off);
    case (len)
      LEN_BYTE: return 1'b1;
      LEN_WORD: return off != 2'd3;
      LEN_LONG: return off == 2'd0;
      default:  return 1'b0;
    endcase
  endfunction

  // Move low-aligned data into its lane.
  function automatic logic [SX_DW-1:0] sx_place(sx_len_e len, logic [1:0] off,
                                                logic [SX_DW-1:0] data);
    return (data & sx_mask(len)) << {off, 3'b000};
  endfunction

  // Pull the selected lanes down to bit 0.
  function automatic logic [SX_DW-1:0] sx_pick(sx_len_e len, logic [1:0] off,
                                               logic [SX_DW-1:0] data);
    return (data >> {off, 3'b000}) & sx_mask(len);
  endfunction

endpackage

// File: rtl/sx_ext_reg.sv
module sx_ext_reg #(
  parameter int unsigned EXT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [EXT_W-1:0] wdata,
  output logic [EXT_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end

endmodule

// File: rtl/sx_decode.sv
module sx_decode
  import sx_pkg::*;
#(
  parameter int unsigned HADDR_W = 40,
  parameter int unsigned DADDR_W = 32,
  parameter int unsigned EXT_W   = 3,
  parameter int unsigned OFFS_W  = 27,
  parameter int unsigned MEM_TAG = 2,
  parameter int unsigned IO_TAG  = 3
) (
  input  logic [HADDR_W-1:0]  addr,
  input  logic                write,
  input  logic [SX_DW-1:0]    wdata,
  input  logic [EXT_W-1:0]    ext,
  output logic [DADDR_W-1:0]  d_addr,
  output logic [SX_LANES-1:0] d_be,
  output logic [SX_DW-1:0]    d_wdata,
  output logic                d_io,
  output logic                d_err,
  output sx_len_e             d_len,
  output logic [1:0]          d_off
);

  localparam int unsigned REG_LSB = OFFS_W + 5;
  localparam int unsigned TAG_W   = HADDR_W - REG_LSB;

  logic [TAG_W-1:0]   tag;
  logic [OFFS_W-1:0]  offs;
  logic               hit_mem, hit_io;
  logic [DADDR_W-1:0] mem_addr, io_addr;
  logic [2:0]         unused_low;

  assign unused_low = addr[2:0];
  assign tag     = addr[HADDR_W-1:REG_LSB];
  assign d_len   = sx_len_e'(addr[4:3]);
  assign d_off   = addr[6:5];
  assign offs    = {addr[REG_LSB-1:7], 2'b00};
  assign hit_mem = (tag == TAG_W'(MEM_TAG));
  assign hit_io  = (tag == TAG_W'(IO_TAG));

  assign io_addr  = DADDR_W'(offs);
  assign mem_addr = io_addr | (DADDR_W'(ext) << (DADDR_W - EXT_W));

  assign d_addr  = hit_io ? io_addr : mem_addr;
  assign d_io    = hit_io;
  assign d_be    = sx_be(d_len, d_off);
  assign d_wdata = write ? sx_place(d_len, d_off, wdata) : '0;
  assign d_err   = !(hit_mem || hit_io) || !sx_len_ok(d_len, d_off);

endmodule

// File: rtl/sx_ctrl.sv
module sx_ctrl
  import sx_pkg::*;
#(
  parameter int unsigned DADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [DADDR_W-1:0]  d_addr,
  input  logic [SX_LANES-1:0] d_be,
  input  logic [SX_DW-1:0]    d_wdata,
  input  logic                d_io,
  input  logic                d_err,
  input  sx_len_e             d_len,
  input  logic [1:0]          d_off,
  output logic                dn_valid,
  input  logic                dn_ready,
  output logic [DADDR_W-1:0]  dn_addr,
  output logic [SX_LANES-1:0] dn_be,
  output logic                dn_write,
  output logic [SX_DW-1:0]    dn_wdata,
  output logic                dn_io,
  input  logic                dn_ack,
  input  logic [SX_DW-1:0]    dn_rdata,
  output logic                rsp_valid,
  output logic [SX_DW-1:0]    rsp_rdata,
  output logic                rsp_err
);

  sx_state_e  state;
  sx_len_e    len_q;
  logic [1:0] off_q;

  assign req_ready = (state == ST_IDLE);
  assign dn_valid  = (state == ST_ISSUE);
  assign rsp_valid = (state == ST_RESP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dn_addr   <= '0;
      dn_be     <= '0;
      dn_write  <= 1'b0;
      dn_wdata  <= '0;
      dn_io     <= 1'b0;
      len_q     <= LEN_BYTE;
      off_q     <= '0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          rsp_rdata <= '0;
          if (d_err) begin
            rsp_err <= 1'b1;
            state   <= ST_RESP;
          end else begin
            rsp_err  <= 1'b0;
            dn_addr  <= d_addr;
            dn_be    <= d_be;
            dn_write <= req_write;
            dn_wdata <= d_wdata;
            dn_io    <= d_io;
            len_q    <= d_len;
            off_q    <= d_off;
            state    <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (dn_ready) state <= ST_WAIT;
        ST_WAIT: if (dn_ack) begin
          rsp_rdata <= dn_write ? '0 : sx_pick(len_q, off_q, dn_rdata);
          state     <= ST_RESP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sparse_xlate.sv
module sparse_xlate
  import sx_pkg::*;
#(
  parameter int unsigned HADDR_W = 40,
  parameter int unsigned DADDR_W = 32,
  parameter int unsigned EXT_W   = 3,
  parameter int unsigned OFFS_W  = 27,
  parameter int unsigned MEM_TAG = 2,
  parameter int unsigned IO_TAG  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_we,
  input  logic [EXT_W-1:0]   ext_wdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [HADDR_W-1:0] req_addr,
  input  logic               req_write,
  input  logic [31:0]        req_wdata,
  output logic               dn_valid,
  input  logic               dn_ready,
  output logic [DADDR_W-1:0] dn_addr,
  output logic [3:0]         dn_be,
  output logic               dn_write,
  output logic [31:0]        dn_wdata,
  output logic               dn_io,
  input  logic               dn_ack,
  input  logic [31:0]        dn_rdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic               rsp_err
);

  logic [EXT_W-1:0]    ext_q;
  logic [DADDR_W-1:0]  d_addr;
  logic [SX_LANES-1:0] d_be;
  logic [SX_DW-1:0]    d_wdata;
  logic                d_io, d_err;
  sx_len_e             d_len;
  logic [1:0]          d_off;

  // Named events for the checker.
  logic ev_accept, ev_accept_err;
  assign ev_accept     = req_valid && req_ready;
  assign ev_accept_err = ev_accept && d_err;

  sx_ext_reg #(.EXT_W(EXT_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .we(ext_we), .wdata(ext_wdata), .q(ext_q)
  );

  sx_decode #(
    .HADDR_W(HADDR_W), .DADDR_W(DADDR_W), .EXT_W(EXT_W),
    .OFFS_W(OFFS_W), .MEM_TAG(MEM_TAG), .IO_TAG(IO_TAG)
  ) u_dec (
    .addr(req_addr), .write(req_write), .wdata(req_wdata), .ext(ext_q),
    .d_addr(d_addr), .d_be(d_be), .d_wdata(d_wdata), .d_io(d_io),
    .d_err(d_err), .d_len(d_len), .d_off(d_off)
  );

  sx_ctrl #(.DADDR_W(DADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .d_addr(d_addr), .d_be(d_be), .d_wdata(d_wdata), .d_io(d_io),
    .d_err(d_err), .d_len(d_len), .d_off(d_off),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr),
    .dn_be(dn_be), .dn_write(dn_write), .dn_wdata(dn_wdata), .dn_io(dn_io),
    .dn_ack(dn_ack), .dn_rdata(dn_rdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

endmodule

// File: rtl/sx_checker.sv
module sx_checker #(
  parameter int unsigned DADDR_W = 32,
  parameter int unsigned OFFS_W  = 27
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               dn_valid,
  input logic               dn_ready,
  input logic [DADDR_W-1:0] dn_addr,
  input logic [3:0]         dn_be,
  input logic               dn_write,
  input logic [31:0]        dn_wdata,
  input logic               dn_io,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic               ev_accept_err
);

  function automatic logic [31:0] lane_mask(logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  // R9
  dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_be)
                              && $stable(dn_wdata) && $stable(dn_write));

  // R9
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && dn_valid));

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8
  err_no_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept_err |=> rsp_valid && rsp_err && !dn_valid);

  // R3
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> dn_be inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'h6, 4'hC, 4'hF});

  // R2
  dn_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> dn_addr[1:0] == 2'b00);

  // R5
  io_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_io |-> dn_addr[DADDR_W-1:OFFS_W] == '0);

  // R6
  wlane_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_write |-> (dn_wdata & ~lane_mask(dn_be)) == 32'h0);

endmodule

bind sparse_xlate sx_checker #(.DADDR_W(DADDR_W), .OFFS_W(OFFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .dn_valid(dn_valid),
  .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_be(dn_be), .dn_write(dn_write),
  .dn_wdata(dn_wdata), .dn_io(dn_io), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .ev_accept_err(ev_accept_err)
);

// File: tb/sim_sparse_xlate.sv
`timescale 1ns/1ps
module sim_sparse_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_we = 1'b0;
  logic [2:0]  ext_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [39:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        dn_valid;
  logic        dn_ready = 1'b0;
  logic [31:0] dn_addr;
  logic [3:0]  dn_be;
  logic        dn_write;
  logic [31:0] dn_wdata;
  logic        dn_io;
  logic        dn_ack = 1'b0;
  logic [31:0] dn_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  int checks = 0;
  int fails  = 0;
  int ext_m  = 0;
  longint last_dn = 0;

  always #4 clk = ~clk;

  sparse_xlate u0 (.*);

  task automatic chk(input string req, input logic ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model, written from the requirements.
  function automatic int tag_of(longint h);  return int'((h >> 32) & 8'hFF); endfunction
  function automatic int len_of(longint h);  return int'((h >> 3) & 3);      endfunction
  function automatic int off_of(longint h);  return int'((h >> 5) & 3);      endfunction
  function automatic longint size_mask(int len);
    if (len == 0) return 64'hFF;
    if (len == 1) return 64'hFFFF;
    return 64'hFFFF_FFFF;
  endfunction
  function automatic bit ref_err(longint h);
    int t = tag_of(h), l = len_of(h), o = off_of(h);
    if (t != 2 && t != 3) return 1;
    if (l == 2) return 1;
    if (l == 1 && o == 3) return 1;
    if (l == 3 && o != 0) return 1;
    return 0;
  endfunction
  function automatic longint ref_addr(longint h);
    longint a = (h >> 5) & 64'h07FF_FFFC;
    if (tag_of(h) == 2) a = a + (longint'(ext_m) * 64'h2000_0000);
    return a;
  endfunction
  function automatic longint ref_be(longint h);
    if (len_of(h) == 3) return 15;
    if (len_of(h) == 1) return 3 << off_of(h);
    return 1 << off_of(h);
  endfunction
  function automatic longint ref_wd(longint h, bit wr, longint wd);
    if (!wr) return 0;
    return ((wd & size_mask(len_of(h))) << (8 * off_of(h))) & 64'hFFFF_FFFF;
  endfunction
  function automatic longint ref_rd(longint h, bit wr, longint rd);
    if (wr) return 0;
    return (rd >> (8 * off_of(h))) & size_mask(len_of(h));
  endfunction

  function automatic logic [39:0] mk(int tag, int da, int len, int junk);
    return {8'(tag), 27'(da), 2'(len), 3'(junk)};
  endfunction

  task automatic set_ext(input int v);
    @(negedge clk); ext_we = 1'b1; ext_wdata = 3'(v);
    @(negedge clk); ext_we = 1'b0;
    ext_m = v;
  endtask

  task automatic xact(input logic [39:0] h, input bit wr, input logic [31:0] wd,
                      input logic [31:0] rd, input int rdly, input int adly);
    bit e = ref_err(h);
    string rq = (tag_of(h) == 3) ? "R5" : "R4";
    @(negedge clk);
    req_valid = 1'b1; req_addr = h; req_write = wr; req_wdata = wd;
    chk("R9 ready when idle", req_ready == 1'b1, req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 busy after accept", req_ready == 1'b0, req_ready, 0);
    if (e) begin
      chk("R8 no downstream on error", dn_valid == 1'b0, dn_valid, 0);
      chk("R8 error response", rsp_valid && rsp_err, {rsp_valid, rsp_err}, 3);
      @(negedge clk);
      chk("R9 error pulse ends", !rsp_valid && req_ready, {rsp_valid, req_ready}, 1);
    end else begin
      chk("R9 dn_valid after accept", dn_valid == 1'b1, dn_valid, 1);
      chk("R2 downstream address", dn_addr == 32'(ref_addr(h)), dn_addr, ref_addr(h));
      chk(rq, dn_addr == 32'(ref_addr(h)), dn_addr, ref_addr(h));
      chk(rq, dn_io == (tag_of(h) == 3), dn_io, tag_of(h) == 3);
      chk("R3 byte enables", dn_be == 4'(ref_be(h)), dn_be, ref_be(h));
      chk("R6 write lanes", dn_wdata == 32'(ref_wd(h, wr, wd)), dn_wdata, ref_wd(h, wr, wd));
      chk("R9 direction", dn_write == wr, dn_write, wr);
      last_dn = dn_addr;
      for (int i = 0; i < rdly; i++) begin
        @(negedge clk);
        chk("R9 held while stalled", dn_valid && dn_addr == 32'(ref_addr(h)), dn_addr, ref_addr(h));
      end
      dn_ready = 1'b1;
      @(negedge clk);
      dn_ready = 1'b0;
      chk("R9 dn_valid drops", !dn_valid && !rsp_valid, {dn_valid, rsp_valid}, 0);
      for (int i = 0; i < adly; i++) begin
        @(negedge clk);
        chk("R9 no early response", !rsp_valid, rsp_valid, 0);
      end
      dn_ack = 1'b1; dn_rdata = rd;
      @(negedge clk);
      dn_ack = 1'b0; dn_rdata = 32'hDEAD_BEEF;
      chk("R9 response after ack", rsp_valid && !rsp_err, {rsp_valid, rsp_err}, 2);
      chk("R7 read data", rsp_rdata == 32'(ref_rd(h, wr, rd)), rsp_rdata, ref_rd(h, wr, rd));
      @(negedge clk);
      chk("R9 pulse ends", !rsp_valid && req_ready, {rsp_valid, req_ready}, 1);
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ready", req_ready == 1'b1, req_ready, 1);
    chk("R1 reset dn_valid", dn_valid == 1'b0, dn_valid, 0);
    chk("R1 reset rsp_valid", rsp_valid == 1'b0, rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", req_ready && !dn_valid && !rsp_valid, req_ready, 1);

    // R1 / R4: extension register starts at zero.
    xact(mk(2, 27'h7FF_FFF0, 0, 0), 0, 0, 32'h1122_3344, 0, 0);

    // R3 / R7: byte reads at every offset.
    for (int o = 0; o < 4; o++)
      xact(mk(2, 27'h012_3450 + o, 0, 0), 0, 0, 32'hA1B2_C3D4, o, 1);
    // R3 / R7: words at offsets 0..2, one longword.
    for (int o = 0; o < 3; o++)
      xact(mk(3, 27'h000_0100 + o, 1, 0), 0, 0, 32'h8765_4321, 0, o);
    xact(mk(2, 27'h000_0200, 3, 0), 0, 0, 32'hCAFE_F00D, 1, 0);

    // R6: writes in each size.
    xact(mk(2, 27'h000_0302, 0, 0), 1, 32'hFFFF_FF5A, 0, 0, 0);
    xact(mk(2, 27'h000_0303, 0, 0), 1, 32'h0000_00C3, 0, 0, 0);
    xact(mk(2, 27'h000_0301, 1, 0), 1, 32'h1234_BEEF, 0, 2, 0);
    xact(mk(3, 27'h000_0304, 3, 0), 1, 32'h0BAD_F00D, 0, 0, 3);

    // R4 / R5: extension register reaches memory space only.
    set_ext(5);
    xact(mk(2, 27'h555_5554, 3, 0), 0, 0, 32'h0102_0304, 0, 0);
    xact(mk(3, 27'h555_5554, 3, 0), 0, 0, 32'h0102_0304, 0, 0);
    set_ext(7);
    xact(mk(2, 27'h000_0010, 0, 0), 1, 32'h77, 0, 0, 0);

    // R2: junk in the ignored low bits.
    xact(mk(2, 27'h000_4001, 0, 5), 0, 0, 32'h5566_7788, 0, 0);
    xact(mk(3, 27'h000_4002, 1, 7), 1, 32'h0000_9ABC, 0, 0, 0);

    // R8: each illegal form.
    xact(mk(2, 27'h000_0000, 2, 0), 0, 0, 0, 0, 0);
    xact(mk(2, 27'h000_0003, 1, 0), 1, 32'h1, 0, 0, 0);
    xact(mk(2, 27'h000_0001, 3, 0), 0, 0, 0, 0, 0);
    xact(mk(7, 27'h000_0000, 0, 0), 0, 0, 0, 0, 0);
    xact(mk(0, 27'h000_0000, 3, 0), 0, 0, 0, 0, 0);

    // R10: split 64-bit access, halves 0x80 apart on the host side.
    begin
      logic [39:0] h0;
      longint a0;
      h0 = mk(2, 27'h0AB_CD00, 3, 0);
      xact(h0, 1, 32'h89AB_CDEF, 0, 0, 0);
      a0 = last_dn;
      xact(h0 + 40'h80, 1, 32'h0123_4567, 0, 0, 0);
      chk("R10 second half address", last_dn == a0 + 4, last_dn, a0 + 4);
    end

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule